// File: doc/BRIEF.md
# Approximate-Load Value Predictor

This block lets a core keep executing when a load tagged as error-tolerant misses in the data cache. On such a miss the core raises a lookup carrying the load address of the instruction (the load PC) and two flags: one copied from the opcode bit that marks the load as approximate, one that reports the miss. One cycle later the block presents a guessed data word with a one-cycle strobe. The register-write and wakeup path can then consume the guess and let the load retire. Precise loads and cache hits are filtered out and never produce a guess.

When the real memory data for such a load returns, the core sends the load PC and the fetched word on a separate training port. Each table slot holds the most recent value, a confirmed stride and a pending delta. A new stride is confirmed only when two successive deltas agree. The block never compares a guess against the data that later arrives. It has no error, flush or recovery output, so a wrong guess simply flows on into the program.

The table is indexed by folding two 8-bit fields of the PC together, with no tag. Loads whose folded indices collide share one slot.

Top module: `approx_value_predictor`

## Requirements
- R1: `pred_valid` is high for exactly one cycle, the cycle after a cycle in which `lk_valid`, `lk_approx` and `lk_miss` are all 1. In every other cycle it is 0.
- R2: A lookup with `lk_approx`=0, or with `lk_miss`=0, or with `lk_valid`=0 is ignored. `pred_valid` stays 0 and `pred_value` keeps its previous value.
- R3: The slot index is `pc[9:2] XOR pc[17:10]`, and no tag is kept. Two PCs that give the same index read and train the same slot.
- R4: The guess is the slot's last value plus its confirmed stride, modulo 2^64. A negative stride wraps in two's complement.
- R5: On an update, delta = new data minus last value. The confirmed stride becomes delta only when delta equals the slot's stored pending delta. Otherwise the confirmed stride is unchanged.
- R6: Every update writes the new data as the last value and writes delta as the pending delta. Nothing is compared with any earlier guess, and the block has no misprediction or recovery output.
- R7: If an update and a qualifying lookup hit the same slot in the same cycle, the guess is computed from the slot contents before that update.
- R8: After reset, every slot holds zero in all fields, `pred_valid` is 0 and `pred_value` is 0. An untrained slot therefore guesses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | PC of the load being looked up |
| lk_approx | input | 1 | Load is marked approximate by its opcode bit |
| lk_miss | input | 1 | Load missed in the data cache |
| upd_valid | input | 1 | Memory fill data is presented for training |
| upd_pc | input | PC_W | PC of the load whose data returned |
| upd_data | input | 64 | Data returned from memory |
| pred_valid | output | 1 | One-cycle strobe: `pred_value` holds a new guess |
| pred_value | output | 64 | Guessed load data |

## Verification
Slot state is only visible through later guesses. A corrupted last value or stride therefore shows up at `pred_value` on the first qualifying lookup to that slot, one cycle after the lookup is issued. A stride that was confirmed too early or too late appears as a wrong increment after exactly three fills of a fresh slot. A slot that was overwritten through the index fold shows up when an aliasing PC is looked up. The same-cycle update and lookup case separates read-before-write ordering from write-first ordering in a single lookup.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  localparam int unsigned WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;

  // guess = last + stride, two's complement wrap
  function automatic word_t lvp_guess(input word_t last, input word_t stride);
    return last + stride;
  endfunction

  // delta observed by a fresh fill
  function automatic word_t lvp_delta(input word_t fresh, input word_t last);
    return fresh - last;
  endfunction
endpackage

// File: rtl/lvp_hash.sv
module lvp_hash #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned LO = 2;
  localparam int unsigned HI = LO + IDX_W;
  localparam int unsigned TOP = HI + IDX_W;

  function automatic logic [IDX_W-1:0] fold(input logic [PC_W-1:0] p);
    return p[LO +: IDX_W] ^ p[HI +: IDX_W];
  endfunction

  assign idx = fold(pc);

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[LO-1:0], pc[PC_W-1:TOP]};
endmodule

// File: rtl/lvp_table.sv
module lvp_table
  import lvp_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output word_t            rd_last,
  output word_t            rd_stride,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  output logic             stride_commit
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  word_t last_q   [DEPTH];
  word_t stride_q [DEPTH];
  word_t cand_q   [DEPTH];

  word_t wr_delta;
  assign wr_delta      = lvp_delta(wr_data, last_q[wr_idx]);
  assign stride_commit = wr_en && (wr_delta == cand_q[wr_idx]);

  assign rd_last   = last_q[rd_idx];
  assign rd_stride = stride_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        last_q[i]   <= '0;
        stride_q[i] <= '0;
        cand_q[i]   <= '0;
      end
    end else if (wr_en) begin
      last_q[wr_idx] <= wr_data;
      cand_q[wr_idx] <= wr_delta;
      if (stride_commit) stride_q[wr_idx] <= wr_delta;
    end
  end

  AST_FILL_BECOMES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> last_q[$past(wr_idx)] == $past(wr_data)); // R6
  AST_STRIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stride_commit) |=> stride_q[$past(wr_idx)] == $past(stride_q[wr_idx])); // R5
  AST_STRIDE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    stride_commit |=> stride_q[$past(wr_idx)] == $past(wr_data) - $past(last_q[wr_idx])); // R5
endmodule

// File: rtl/lvp_out.sv
module lvp_out
  import lvp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  word_t last,
  input  word_t stride,
  output logic  pred_valid,
  output word_t pred_value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_value <= '0;
    end else begin
      pred_valid <= fire;
      if (fire) pred_value <= lvp_guess(last, stride);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pred_value)); // R2
endmodule

// File: rtl/approx_value_predictor.sv
module approx_value_predictor
  import lvp_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_approx,
  input  logic            lk_miss,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [63:0]     upd_data,
  output logic            pred_valid,
  output logic [63:0]     pred_value
);
  logic             lk_fire;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  word_t            rd_last;
  word_t            rd_stride;
  logic             stride_commit;
  logic             same_slot_evt;

  assign lk_fire       = lk_valid && lk_approx && lk_miss;
  assign same_slot_evt = lk_fire && upd_valid && (lk_idx == upd_idx);

  lvp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_lk (.pc(lk_pc), .idx(lk_idx));
  lvp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_up (.pc(upd_pc), .idx(upd_idx));

  lvp_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_last(rd_last), .rd_stride(rd_stride),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_data(upd_data),
    .stride_commit(stride_commit)
  );

  lvp_out u_out (
    .clk(clk), .rst_n(rst_n), .fire(lk_fire),
    .last(rd_last), .stride(rd_stride),
    .pred_valid(pred_valid), .pred_value(pred_value)
  );

  logic unused_commit;
  assign unused_commit = stride_commit;

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(lk_valid && lk_approx && lk_miss)); // R1
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_approx && lk_miss) |=> pred_valid); // R1
  AST_GUESS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> pred_value == $past(rd_last) + $past(rd_stride)); // R4
  AST_OLD_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    same_slot_evt |=> pred_value == $past(rd_last) + $past(rd_stride)); // R7
endmodule

// File: tb/tb_approx_value_predictor.sv
`timescale 1ns/1ps
module tb_approx_value_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_approx = 0, lk_miss = 0, upd_valid = 0;
  logic [31:0] lk_pc = '0, upd_pc = '0;
  logic [63:0] upd_data = '0;
  logic        pred_valid;
  logic [63:0] pred_value;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  approx_value_predictor dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_approx(lk_approx), .lk_miss(lk_miss), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_data(upd_data),
    .pred_valid(pred_valid), .pred_value(pred_value)
  );

  localparam logic [31:0] PC_A = 32'h0000_0400; // slot 1
  localparam logic [31:0] PC_B = 32'h0000_0004; // slot 1 too
  localparam logic [31:0] PC_C = 32'h0000_0404; // slot 0
  localparam logic [31:0] PC_D = 32'h0000_0008; // slot 2

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic ap, input logic ms, input logic v);
    @(negedge clk);
    lk_valid = v; lk_pc = pc; lk_approx = ap; lk_miss = ms;
    @(negedge clk);
    lk_valid = 0; lk_approx = 0; lk_miss = 0;
  endtask

  task automatic fill(input logic [31:0] pc, input logic [63:0] d);
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_data = d;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic t_reset();
    chk("R8 pred_valid", {63'd0, pred_valid}, 64'd0);
    chk("R8 pred_value", pred_value, 64'd0);
    lookup(PC_C, 1, 1, 1);
    chk("R1 strobe", {63'd0, pred_valid}, 64'd1);
    chk("R8 untrained guess", pred_value, 64'd0);
    @(negedge clk);
    chk("R1 strobe one cycle", {63'd0, pred_valid}, 64'd0);
  endtask

  task automatic t_train();
    fill(PC_A, 64'd100);
    fill(PC_A, 64'd110);
    lookup(PC_A, 1, 1, 1);
    chk("R5 no stride yet", pred_value, 64'd110);
    fill(PC_A, 64'd120);
    lookup(PC_A, 1, 1, 1);
    chk("R4 last+stride", pred_value, 64'd130);
    fill(PC_A, 64'd150);
    lookup(PC_A, 1, 1, 1);
    chk("R5 stride kept on new delta", pred_value, 64'd160);
    fill(PC_A, 64'd180);
    lookup(PC_A, 1, 1, 1);
    chk("R6 last and repeat stride", pred_value, 64'd210);
  endtask

  task automatic t_filter();
    lookup(PC_C, 0, 1, 1);
    chk("R2 precise no strobe", {63'd0, pred_valid}, 64'd0);
    chk("R2 precise value held", pred_value, 64'd210);
    lookup(PC_C, 1, 0, 1);
    chk("R2 hit no strobe", {63'd0, pred_valid}, 64'd0);
    chk("R2 hit value held", pred_value, 64'd210);
    lookup(PC_C, 1, 1, 0);
    chk("R1 no valid no strobe", {63'd0, pred_valid}, 64'd0);
    chk("R2 invalid value held", pred_value, 64'd210);
  endtask

  task automatic t_alias();
    lookup(PC_B, 1, 1, 1);
    chk("R3 alias shares slot", pred_value, 64'd210);
    lookup(PC_C, 1, 1, 1);
    chk("R3 other slot untouched", pred_value, 64'd0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    upd_valid = 1; upd_pc = PC_A; upd_data = 64'd240;
    lk_valid = 1; lk_pc = PC_A; lk_approx = 1; lk_miss = 1;
    @(negedge clk);
    upd_valid = 0; lk_valid = 0; lk_approx = 0; lk_miss = 0;
    chk("R7 old contents seen", pred_value, 64'd210);
    lookup(PC_A, 1, 1, 1);
    chk("R7 update applied after", pred_value, 64'd270);
  endtask

  task automatic t_wrap();
    fill(PC_D, 64'd5);
    fill(PC_D, 64'd3);
    fill(PC_D, 64'd1);
    lookup(PC_D, 1, 1, 1);
    chk("R4 negative stride wraps", pred_value, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_train();
    t_filter();
    t_alias();
    t_collide();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule